// File: doc/BRIEF.md
# Dynamic Clock Phase Step Manager

This block moves the phase of a clock generator's capture outputs during calibration. A caller asks for a phase increase or a phase decrease on one selected output. The block turns each accepted request into a single fine step, one eighth of the oscillator period, through a step, up/down and select handshake. It holds the step request until the clock generator acknowledges it. The outputs are adjusted one at a time while every clock keeps running. The generator's configuration chain is never reloaded.

For each output the block keeps a signed count of the net number of steps taken since reset. A request that would push a count beyond its configured upper or lower limit is consumed without issuing a step. The per-output boundary flags then tell the calibration and tracking logic to stop sweeping in that direction. Only one step is in flight at any time. A clear input returns every count to zero.

Top module: `phase_step_mgr`

## Requirements
- R1: After reset, every count reads zero, `req_ready` is 1, `pll_step` is 0, and both flags of every output are 0.
- R2: A request accepted in a cycle (`req_valid` high while `req_ready` is high) that is not blocked raises `pll_step` in the next cycle. In that cycle `pll_updn` equals the request's `req_up` (1 = increase, 0 = decrease) and `pll_sel` equals `req_sel`. All three hold until the cycle in which `pll_ack` is sampled high.
- R3: When `pll_ack` is sampled high while `pll_step` is high, `pll_step` falls in the next cycle. In that same next cycle the count of the selected output has moved by exactly +1 for an increase or −1 for a decrease.
- R4: While a step is outstanding, `req_ready` is 0 and requests are not accepted. `req_ready` returns to 1 in the cycle after the acknowledge.
- R5: An increase request on an output whose count equals `LIM_HI` is consumed without a step, and its count is unchanged. The same holds for a decrease request on an output whose count equals `LIM_LO`.
- R6: `at_max[k]` is 1 exactly when count k equals `LIM_HI`, and `at_min[k]` is 1 exactly when it equals `LIM_LO`. Counts never leave the range [`LIM_LO`, `LIM_HI`]. Count k is the two's-complement field `shift_count[k*CNT_W +: CNT_W]`, with `CNT_W` = clog2(`STEPS_PER_PERIOD`)+2, so that a full period of steps in either direction fits.
- R7: When `clr` is sampled high, all counts read zero in the next cycle. This holds even when an acknowledge is sampled in the same cycle.
- R8: A completed step changes only the count of the output it was issued for.
- R9: `pll_ack` sampled while no step is outstanding changes neither any count nor the handshake outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| clr | input | 1 | Zero all counts |
| req_valid | input | 1 | Step request |
| req_up | input | 1 | 1 = increase phase, 0 = decrease |
| req_sel | input | SEL_W | Output to step |
| req_ready | output | 1 | Request accepted when high |
| pll_step | output | 1 | Step request to the clock generator, held until acknowledged |
| pll_updn | output | 1 | Step direction to the clock generator |
| pll_sel | output | SEL_W | Output selected for the step |
| pll_ack | input | 1 | Step-done pulse from the clock generator |
| shift_count | output | NUM_OUT*CNT_W | Signed net step count per output |
| at_max | output | NUM_OUT | Count equals the upper limit |
| at_min | output | NUM_OUT | Count equals the lower limit |

## Verification
On every cycle the assertions check the following:
- counts stay inside the limits and move by at most one step unless cleared;
- a clear always yields zero;
- a step request and its select and direction hold steady until acknowledged, and drop right after the acknowledge;
- a blocked request never raises a step;
- no two outputs update in the same cycle.

The bench's reference model is needed to show the remaining behaviour:
- the right output moves in the right direction by exactly one;
- the flags track the limit values;
- a clear wins over a simultaneous acknowledge;
- stray acknowledges and requests made while busy have no effect.

// File: rtl/phase_step_pkg.sv
package phase_step_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } step_state_t;

  function automatic int sel_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/phase_shift_counter.sv
module phase_shift_counter #(
  parameter int CNT_W  = 5,
  parameter int LIM_HI = 8,
  parameter int LIM_LO = -8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr_i,
  input  logic                    inc_i,
  input  logic                    dec_i,
  output logic signed [CNT_W-1:0] cnt_o,
  output logic                    at_hi_o,
  output logic                    at_lo_o
);

  localparam logic signed [CNT_W-1:0] HI_V  = CNT_W'(LIM_HI);
  localparam logic signed [CNT_W-1:0] LO_V  = CNT_W'(LIM_LO);
  localparam logic signed [CNT_W-1:0] ONE_V = CNT_W'(1);

  logic signed [CNT_W-1:0] cnt_q;
  logic signed [CNT_W-1:0] cnt_d;
  logic                    cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = clr_i | inc_i | dec_i;
    if (clr_i) begin
      cnt_d = '0;
    end else if (inc_i && (cnt_q != HI_V)) begin
      cnt_d = cnt_q + ONE_V;
    end else if (dec_i && (cnt_q != LO_V)) begin
      cnt_d = cnt_q - ONE_V;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o   = cnt_q;
  assign at_hi_o = (cnt_q == HI_V);
  assign at_lo_o = (cnt_q == LO_V);

  // R6
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_o <= HI_V) && (cnt_o >= LO_V));

  // R3
  cnt_single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> (cnt_o == $past(cnt_o)) || (cnt_o == $past(cnt_o) + ONE_V) ||
               (cnt_o == $past(cnt_o) - ONE_V));

  // R7
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_o == '0));

endmodule

// File: rtl/phase_step_fsm.sv
module phase_step_fsm
  import phase_step_pkg::*;
#(
  parameter int NUM_OUT = 4,
  parameter int SEL_W   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid_i,
  input  logic               req_up_i,
  input  logic [SEL_W-1:0]   req_sel_i,
  input  logic [NUM_OUT-1:0] hi_i,
  input  logic [NUM_OUT-1:0] lo_i,
  input  logic               ack_i,
  output logic               ready_o,
  output logic               step_o,
  output logic               updn_o,
  output logic [SEL_W-1:0]   sel_o,
  output logic [NUM_OUT-1:0] done_inc_o,
  output logic [NUM_OUT-1:0] done_dec_o
);

  localparam logic [SEL_W:0] NUM_V = (SEL_W+1)'(NUM_OUT);

  step_state_t      state_q, state_d;
  logic [SEL_W-1:0] sel_q, sel_d;
  logic             up_q, up_d;
  logic             lat_en;
  logic             sel_ok;
  logic             blocked;

  always_comb begin
    sel_ok  = ({1'b0, req_sel_i} < NUM_V);
    blocked = !sel_ok || (req_up_i ? hi_i[req_sel_i] : lo_i[req_sel_i]);
  end

  always_comb begin
    state_d    = state_q;
    sel_d      = sel_q;
    up_d       = up_q;
    lat_en     = 1'b0;
    done_inc_o = '0;
    done_dec_o = '0;
    case (state_q)
      ST_IDLE: begin
        if (req_valid_i && !blocked) begin
          state_d = ST_WAIT;
          sel_d   = req_sel_i;
          up_d    = req_up_i;
          lat_en  = 1'b1;
        end
      end
      ST_WAIT: begin
        if (ack_i) begin
          state_d            = ST_IDLE;
          done_inc_o[sel_q]  = up_q;
          done_dec_o[sel_q]  = !up_q;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      up_q  <= 1'b0;
    end else if (lat_en) begin
      sel_q <= sel_d;
      up_q  <= up_d;
    end
  end

  assign ready_o = (state_q == ST_IDLE);
  assign step_o  = (state_q == ST_WAIT);
  assign updn_o  = up_q;
  assign sel_o   = sel_q;

  // R4
  one_in_flight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_o && !ack_i) |=> step_o && !ready_o && $stable(sel_o) && $stable(updn_o));

  // R3
  ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_o && ack_i) |=> !step_o && ready_o);

  // R5
  blocked_no_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_o && req_valid_i && blocked) |=> !step_o);

  // R2
  accept_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_o && req_valid_i && !blocked) |=> step_o && (sel_o == $past(req_sel_i)) &&
                                            (updn_o == $past(req_up_i)));

endmodule

// File: rtl/phase_step_mgr.sv
module phase_step_mgr
  import phase_step_pkg::*;
#(
  parameter int NUM_OUT          = 4,
  parameter int STEPS_PER_PERIOD = 8,
  parameter int LIM_HI           = 8,
  parameter int LIM_LO           = -8,
  localparam int SEL_W           = sel_width(NUM_OUT),
  localparam int CNT_W           = $clog2(STEPS_PER_PERIOD) + 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr,
  input  logic                     req_valid,
  input  logic                     req_up,
  input  logic [SEL_W-1:0]         req_sel,
  output logic                     req_ready,
  output logic                     pll_step,
  output logic                     pll_updn,
  output logic [SEL_W-1:0]         pll_sel,
  input  logic                     pll_ack,
  output logic [NUM_OUT*CNT_W-1:0] shift_count,
  output logic [NUM_OUT-1:0]       at_max,
  output logic [NUM_OUT-1:0]       at_min
);

  logic [1:0]         rst_sync_q;
  logic               rst_int_n;
  logic [NUM_OUT-1:0] done_inc;
  logic [NUM_OUT-1:0] done_dec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  phase_step_fsm #(
    .NUM_OUT (NUM_OUT),
    .SEL_W   (SEL_W)
  ) fsm_i (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .req_valid_i (req_valid),
    .req_up_i    (req_up),
    .req_sel_i   (req_sel),
    .hi_i        (at_max),
    .lo_i        (at_min),
    .ack_i       (pll_ack),
    .ready_o     (req_ready),
    .step_o      (pll_step),
    .updn_o      (pll_updn),
    .sel_o       (pll_sel),
    .done_inc_o  (done_inc),
    .done_dec_o  (done_dec)
  );

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_cnt
    logic signed [CNT_W-1:0] cnt_w;
    phase_shift_counter #(
      .CNT_W  (CNT_W),
      .LIM_HI (LIM_HI),
      .LIM_LO (LIM_LO)
    ) cnt_i (
      .clk     (clk),
      .rst_n   (rst_int_n),
      .clr_i   (clr),
      .inc_i   (done_inc[g]),
      .dec_i   (done_dec[g]),
      .cnt_o   (cnt_w),
      .at_hi_o (at_max[g]),
      .at_lo_o (at_min[g])
    );
    assign shift_count[g*CNT_W +: CNT_W] = cnt_w;
  end

  // R8
  single_update_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    $onehot0({done_inc, done_dec}));

endmodule

// File: tb/phase_step_mgr_tb.sv
module phase_step_mgr_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_OUT    = 4;
  localparam int STEPS      = 8;
  localparam int HI         = 8;
  localparam int LO         = -8;
  localparam int SEL_W      = 2;
  localparam int CNT_W      = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr_t = 1'b0, clr_a = 1'b0;
  logic req_valid = 1'b0, req_up = 1'b0;
  logic [SEL_W-1:0] req_sel = '0;
  logic ack_g = 1'b0, ack_s = 1'b0;
  logic req_ready, pll_step, pll_updn;
  logic [SEL_W-1:0] pll_sel;
  logic [NUM_OUT*CNT_W-1:0] shift_count;
  logic [NUM_OUT-1:0] at_max, at_min;
  logic clr, pll_ack;

  assign clr     = clr_t | clr_a;
  assign pll_ack = ack_g | ack_s;

  phase_step_mgr #(
    .NUM_OUT(NUM_OUT), .STEPS_PER_PERIOD(STEPS), .LIM_HI(HI), .LIM_LO(LO)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .clr(clr), .req_valid(req_valid), .req_up(req_up),
    .req_sel(req_sel), .req_ready(req_ready), .pll_step(pll_step), .pll_updn(pll_updn),
    .pll_sel(pll_sel), .pll_ack(pll_ack), .shift_count(shift_count),
    .at_max(at_max), .at_min(at_min)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit cmp_en = 1'b0;
  int ack_lat = 2;
  int wcnt = 0;
  bit clr_on_ack = 1'b0;
  bit saw_step = 1'b0;
  int cyc = 0;

  int  m_cnt [NUM_OUT];
  int  nc    [NUM_OUT];
  bit  m_busy;
  int  m_sel;
  bit  m_up;
  bit  blk;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic int dut_cnt(input int k);
    logic signed [CNT_W-1:0] v;
    v = shift_count[k*CNT_W +: CNT_W];
    return int'(v);
  endfunction

  // behavioural reference model
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_OUT; i++) m_cnt[i] = 0;
      m_busy = 1'b0; m_sel = 0; m_up = 1'b0;
    end else begin
      for (int i = 0; i < NUM_OUT; i++) nc[i] = m_cnt[i];
      if (m_busy) begin
        if (pll_ack) begin
          nc[m_sel] = m_up ? nc[m_sel] + 1 : nc[m_sel] - 1;
          m_busy = 1'b0;
        end
      end else if (req_valid) begin
        blk = req_up ? (m_cnt[req_sel] == HI) : (m_cnt[req_sel] == LO);
        if (!blk) begin
          m_busy = 1'b1; m_sel = int'(req_sel); m_up = req_up;
        end
      end
      if (clr) for (int i = 0; i < NUM_OUT; i++) nc[i] = 0;
      for (int i = 0; i < NUM_OUT; i++) m_cnt[i] = nc[i];
    end
  end

  // per-cycle comparison, then clock generator acknowledge model
  always @(negedge clk) begin
    cyc++;
    if (cmp_en) begin
      chk("R4 req_ready", int'(req_ready), int'(!m_busy));
      chk("R2 pll_step", int'(pll_step), int'(m_busy));
      if (m_busy) begin
        chk("R2 pll_updn", int'(pll_updn), int'(m_up));
        chk("R2 pll_sel", int'(pll_sel), m_sel);
      end
      for (int k = 0; k < NUM_OUT; k++) begin
        chk("R3 count", dut_cnt(k), m_cnt[k]);
        chk("R6 at_max", int'(at_max[k]), int'(m_cnt[k] == HI));
        chk("R6 at_min", int'(at_min[k]), int'(m_cnt[k] == LO));
      end
    end
    ack_g = 1'b0;
    clr_a = 1'b0;
    if (pll_step) begin
      saw_step = 1'b1;
      if (wcnt + 1 >= ack_lat) begin
        ack_g = 1'b1; wcnt = 0;
        if (clr_on_ack) clr_a = 1'b1;
      end else begin
        wcnt++;
      end
    end else begin
      wcnt = 0;
    end
  end

  task automatic do_req(input int sel, input bit up);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_up = up; req_sel = SEL_W'(sel);
    @(negedge clk);
    req_valid = 1'b0;
    while (!req_ready) @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(4);
    // R1 reset state
    chk("R1 req_ready", int'(req_ready), 1);
    chk("R1 pll_step", int'(pll_step), 0);
    for (int k = 0; k < NUM_OUT; k++) chk("R1 count", dut_cnt(k), 0);
    chk("R1 flags", int'({at_max, at_min}), 0);
    cmp_en = 1'b1;

    // R2 R3 single increase
    do_req(0, 1'b1);
    idle(1);
    chk("R3 inc out0", dut_cnt(0), 1);
    // R8 other outputs untouched
    chk("R8 out1", dut_cnt(1), 0);

    // decreases with varying ack latency
    ack_lat = 1;
    do_req(1, 1'b0);
    ack_lat = 5;
    do_req(1, 1'b0);
    idle(1);
    chk("R3 dec out1", dut_cnt(1), -2);

    // R4 request held while busy
    ack_lat = 4;
    do_req(2, 1'b1);
    @(negedge clk);
    req_valid = 1'b1; req_up = 1'b1; req_sel = 2'd3;
    do_req(2, 1'b1);
    idle(2);
    req_valid = 1'b0;
    idle(8);

    // R5 R6 sweep output 2 to the upper limit
    ack_lat = 2;
    while (dut_cnt(2) < HI) do_req(2, 1'b1);
    idle(1);
    chk("R6 at_max out2", int'(at_max[2]), 1);
    saw_step = 1'b0;
    do_req(2, 1'b1);
    idle(3);
    chk("R5 blocked up no step", int'(saw_step), 0);
    chk("R5 blocked up count", dut_cnt(2), HI);

    // sweep output 3 to the lower limit
    ack_lat = 1;
    while (dut_cnt(3) > LO) do_req(3, 1'b0);
    idle(1);
    chk("R6 at_min out3", int'(at_min[3]), 1);
    saw_step = 1'b0;
    do_req(3, 1'b0);
    idle(3);
    chk("R5 blocked down no step", int'(saw_step), 0);
    chk("R5 blocked down count", dut_cnt(3), LO);
    do_req(3, 1'b1);
    idle(1);
    chk("R6 leave min", int'(at_min[3]), 0);

    // R9 stray acknowledge
    @(negedge clk);
    ack_s = 1'b1;
    @(negedge clk);
    ack_s = 1'b0;
    idle(1);
    chk("R9 stray ack count", dut_cnt(2), HI);
    chk("R9 stray ack step", int'(pll_step), 0);

    // R7 plain clear
    @(negedge clk);
    clr_t = 1'b1;
    @(negedge clk);
    clr_t = 1'b0;
    for (int k = 0; k < NUM_OUT; k++) chk("R7 clear", dut_cnt(k), 0);

    // R7 clear wins over simultaneous ack
    do_req(1, 1'b1);
    clr_on_ack = 1'b1;
    ack_lat = 3;
    do_req(0, 1'b0);
    clr_on_ack = 1'b0;
    idle(1);
    chk("R7 clear with ack out0", dut_cnt(0), 0);
    chk("R7 clear with ack out1", dut_cnt(1), 0);

    idle(3);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 50000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule